// File: doc/BRIEF.md
# Triangle-Carrier Complementary PWM Generator

This block drives one half-bridge leg. It runs an up/down counter that forms a symmetric triangular carrier between zero and a programmable peak. It compares the carrier with a duty reference and turns the result into a complementary gate pair, A and B. A protective dead time is placed in front of every rising gate edge, so the two switches never conduct together. A single polarity control flips both gates as a pair. Each gate also has its own enable, so either one can be parked in its off state during bring-up without rewiring.

The duty reference on the `cmp` port acts as a shadow value. It is copied into the working compare register only at carrier extrema. The elaboration parameter `UPD_PEAK` fixes, for the life of the build, whether that copy happens at the trough only or at both trough and peak. A one-cycle strobe on `evt` marks every trough and peak, so the surrounding control logic can pace its reference updates to the carrier.

Top module: `pwm_tri_comp`

## Requirements
- R1: With a stable `period` of P >= 2, the carrier moves one step per clock from 0 up to P and back down to 0, so one full carrier cycle lasts 2P clocks and successive `evt` pulses are exactly P clocks apart.
- R2: With zero dead time, no inversion and both enables high, `out_a` is high for exactly 2C-1 of every 2P clocks when 1 <= C <= P, and `out_b` is the bitwise complement of `out_a` every cycle. C = 0 keeps A low and B high. C > P keeps A high and B low.
- R3: A rising gate edge is postponed by `dead` (D) clocks, while a falling edge is not delayed. With 1 <= C <= P and pulses longer than D, A is high for 2C-1-D clocks and B is high for 2P-2C+1-D clocks per carrier cycle. After A falls, B stays low for exactly D clocks before it rises.
- R4: Without inversion, `out_a` and `out_b` are never high in the same cycle.
- R5: `invert` = 1 flips both outputs together. The per-cycle high counts become 2P minus the uninverted counts, and the two outputs are never low in the same cycle.
- R6: An output whose enable is low sits at its off level after polarity is applied: constant 0 when `invert` = 0 and constant 1 when `invert` = 1. The other output keeps running unchanged.
- R7: With `UPD_PEAK` = 0, a new `cmp` value takes effect only when the carrier leaves zero. A write made on the rising slope yields one A pulse of Cold+Cnew-1 clocks, followed by pulses of 2Cnew-1.
- R8: With `UPD_PEAK` = 1, a new `cmp` value also takes effect when the carrier leaves its peak. The same write yields an A pulse of 2Cnew-1 clocks at once.
- R9: `evt` is high for one clock per carrier extremum and low in the clock that follows it, when P >= 2.
- R10: While `rst_n` is low, `out_a`, `out_b` and `evt` are all 0, whatever the values on `invert` and the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period | input | CNT_W | Carrier peak value P |
| cmp | input | CNT_W | Shadow duty reference C |
| dead | input | DT_W | Dead time in clocks |
| invert | input | 1 | Flip polarity of both gates |
| en_a | input | 1 | Enable for gate A |
| en_b | input | 1 | Enable for gate B |
| out_a | output | 1 | Gate A |
| out_b | output | 1 | Gate B (complement of A) |
| evt | output | 1 | One-cycle strobe at carrier trough and peak |

## Verification
Counted from the clock that sets a carrier value, `evt` follows one clock later and the gates follow two clocks later, plus D on a rising edge. Changes on `invert` and the enables reach the pins after one clock. Each configuration step waits more than two carrier cycles plus the dead time before it measures. Most checks count high cycles over a window of exactly 2P clocks, and that count is the same whatever the carrier phase. The update and dead-gap checks instead lock onto an observed `evt` or gate edge and measure run lengths and gaps from there, so they never depend on an assumed absolute cycle number.

// File: rtl/pwm_tri_comp.sv
`timescale 1ns/1ps
module pwm_tri_comp #(
  parameter int CNT_W    = 16,
  parameter int DT_W     = 8,
  parameter bit UPD_PEAK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  input  logic [DT_W-1:0]  dead,
  input  logic             invert,
  input  logic             en_a,
  input  logic             en_b,
  output logic             out_a,
  output logic             out_b,
  output logic             evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cmp_act;
  logic             up;
  logic [1:0]       des, dt_out;

  wire at_min = (cnt == '0);
  wire at_max = (cnt == period) && (period != '0);
  wire load   = at_min || (UPD_PEAK && at_max);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (cnt < period) cnt <= cnt + ONE;
      else begin
        up <= 1'b0;
        if (cnt != '0) cnt <= cnt - ONE;
      end
    end else begin
      if (cnt != '0) cnt <= cnt - ONE;
      else begin
        up <= 1'b1;
        if (period != '0) cnt <= cnt + ONE;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_act <= '0;
      evt     <= 1'b0;
    end else begin
      evt <= at_min || at_max;
      if (load) cmp_act <= cmp;
    end

  assign des[0] = (cnt < cmp_act);
  assign des[1] = ~des[0];

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [DT_W-1:0] wait_q;
    logic            on_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wait_q <= '0;
        on_q   <= 1'b0;
      end else if (!des[g]) begin
        wait_q <= '0;
        on_q   <= 1'b0;
      end else if (wait_q >= dead) begin
        on_q   <= 1'b1;
      end else begin
        wait_q <= wait_q + DT_W'(1);
      end
    assign dt_out[g] = on_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= (en_a & dt_out[0]) ^ invert;
      out_b <= (en_b & dt_out[1]) ^ invert;
    end

endmodule

// File: rtl/pwm_tri_comp_chk.sv
`timescale 1ns/1ps
module pwm_tri_comp_chk #(
  parameter int CNT_W    = 16,
  parameter bit UPD_PEAK = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic [1:0]       des,
  input logic [1:0]       dt_out,
  input logic             en_a,
  input logic             invert,
  input logic             out_a,
  input logic             evt
);

  logic       seen;
  logic [1:0] calm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= 1'b0;
      calm <= '0;
    end else begin
      seen <= 1'b1;
      calm <= (period != $past(period)) ? 2'd0 : ((calm == 2'd3) ? 2'd3 : calm + 2'd1);
    end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(period) != '0 && $stable(period)) |->
      ({1'b0, cnt} == {1'b0, $past(cnt)} + (CNT_W+1)'(1)) ||
      ({1'b0, cnt} + (CNT_W+1)'(1) == {1'b0, $past(cnt)}));

  p_fall_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !des[0] |=> !dt_out[0]);

  p_fall_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !des[1] |=> !dt_out[1]);

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dt_out[0] && dt_out[1]));

  p_off_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(en_a)) |-> (out_a == $past(invert)));

  p_evt_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && evt && calm == 2'd3 && period > CNT_W'(1)) |=> !evt);

  if (!UPD_PEAK) begin : g_trough
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$stable(cmp_act)) |-> ($past(cnt) == '0));
  end else begin : g_both
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$stable(cmp_act)) |-> ($past(cnt) == '0 || $past(cnt) == $past(period)));
  end

endmodule

bind pwm_tri_comp pwm_tri_comp_chk #(.CNT_W(CNT_W), .UPD_PEAK(UPD_PEAK)) u_chk (
  .clk(clk), .rst_n(rst_n), .period(period), .cnt(cnt), .cmp_act(cmp_act),
  .des(des), .dt_out(dt_out), .en_a(en_a), .invert(invert), .out_a(out_a), .evt(evt)
);

// File: tb/sim_pwm_tri_comp.sv
`timescale 1ns/1ps
module sim_pwm_tri_comp;
  localparam int CW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] period = '0, cmp = '0;
  logic [DW-1:0] dead = '0;
  logic invert = 1'b0, en_a = 1'b1, en_b = 1'b1;
  logic out_a, out_b, evt, out_a1, out_b1, evt1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_tri_comp #(.CNT_W(CW), .DT_W(DW), .UPD_PEAK(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .cmp(cmp), .dead(dead), .invert(invert),
    .en_a(en_a), .en_b(en_b), .out_a(out_a), .out_b(out_b), .evt(evt));

  pwm_tri_comp #(.CNT_W(CW), .DT_W(DW), .UPD_PEAK(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .period(period), .cmp(cmp), .dead(dead), .invert(invert),
    .en_a(en_a), .en_b(en_b), .out_a(out_a1), .out_b(out_b1), .evt(evt1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cfg(input int p, input int c, input int d, input bit inv, input bit ea, input bit eb);
    @(negedge clk);
    period = CW'(p); cmp = CW'(c); dead = DW'(d);
    invert = inv; en_a = ea; en_b = eb;
    repeat (4*p + d + 8) @(negedge clk);
  endtask

  task automatic win(input int len, output int ha, output int hb, output int both_hi,
                     output int both_lo, output int mism);
    ha = 0; hb = 0; both_hi = 0; both_lo = 0; mism = 0;
    for (int i = 0; i < len; i++) begin
      ha += int'(out_a); hb += int'(out_b);
      if (out_a && out_b) both_hi++;
      if (!out_a && !out_b) both_lo++;
      if (out_b == out_a) mism++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    invert = 1'b1; period = CW'(8); cmp = CW'(3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_a && !out_b && !evt, "R10 reset outputs", int'({out_a, out_b, evt}), 0);
    end
    rst_n = 1'b1;
    invert = 1'b0;
  endtask

  task automatic t_strobe();
    int k;
    cfg(6, 2, 0, 0, 1, 1);
    k = 0;
    while (!evt && k < 50) begin @(negedge clk); k++; end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!evt, "R9 strobe width", int'(evt), 0);
      k = 1;
      while (!evt && k < 50) begin @(negedge clk); k++; end
      chk(k == 6, "R1 strobe spacing", k, 6);
    end
  endtask

  task automatic t_duty();
    int ps[4] = '{10, 10, 7, 8};
    int cs[4] = '{5, 1, 3, 8};
    int ha, hb, bh, bl, mm;
    for (int i = 0; i < 4; i++) begin
      cfg(ps[i], cs[i], 0, 0, 1, 1);
      win(2*ps[i], ha, hb, bh, bl, mm);
      chk(ha == 2*cs[i]-1, "R2 A high count", ha, 2*cs[i]-1);
      chk(hb == 2*ps[i]-2*cs[i]+1, "R2 B high count", hb, 2*ps[i]-2*cs[i]+1);
      chk(mm == 0, "R2 B complement", mm, 0);
    end
    cfg(9, 0, 0, 0, 1, 1);
    win(18, ha, hb, bh, bl, mm);
    chk(ha == 0 && hb == 18, "R2 cmp zero", ha*100+hb, 18);
    cfg(9, 12, 0, 0, 1, 1);
    win(18, ha, hb, bh, bl, mm);
    chk(ha == 18 && hb == 0, "R2 cmp above period", ha*100+hb, 1800);
  endtask

  task automatic t_dead();
    int ha, hb, bh, bl, mm, g;
    bit pa;
    cfg(10, 5, 3, 0, 1, 1);
    win(20, ha, hb, bh, bl, mm);
    chk(ha == 6, "R3 A high with dead", ha, 6);
    chk(hb == 8, "R3 B high with dead", hb, 8);
    chk(bh == 0, "R4 no overlap", bh, 0);
    pa = out_a; g = 0;
    while (!(pa && !out_a) && g < 100) begin pa = out_a; @(negedge clk); g++; end
    g = 0;
    while (!out_b && g < 100) begin g++; @(negedge clk); end
    chk(g == 3, "R3 gap after A falls", g, 3);
    cfg(12, 4, 5, 0, 1, 1);
    win(24, ha, hb, bh, bl, mm);
    chk(ha == 2 && hb == 12, "R3 long dead counts", ha*100+hb, 212);
    chk(bh == 0, "R4 no overlap long dead", bh, 0);
  endtask

  task automatic t_inv();
    int ha, hb, bh, bl, mm;
    cfg(10, 5, 3, 1, 1, 1);
    win(20, ha, hb, bh, bl, mm);
    chk(ha == 14, "R5 inverted A count", ha, 14);
    chk(hb == 12, "R5 inverted B count", hb, 12);
    chk(bl == 0, "R5 never both low", bl, 0);
  endtask

  task automatic t_en();
    int ha, hb, bh, bl, mm;
    cfg(10, 5, 3, 0, 0, 1);
    win(20, ha, hb, bh, bl, mm);
    chk(ha == 0 && hb == 8, "R6 A disabled", ha*100+hb, 8);
    cfg(10, 5, 3, 1, 0, 1);
    win(20, ha, hb, bh, bl, mm);
    chk(ha == 20 && hb == 12, "R6 A disabled inverted", ha*100+hb, 2012);
    cfg(10, 5, 3, 0, 1, 0);
    win(20, ha, hb, bh, bl, mm);
    chk(ha == 6 && hb == 0, "R6 B disabled", ha*100+hb, 600);
  endtask

  task automatic t_upd();
    int r0[2], r1[2];
    int k0, k1, run0, run1, g;
    bit p0, p1;
    cfg(10, 3, 0, 0, 1, 1);
    g = 0;
    while (!(evt && out_a) && g < 100) begin @(negedge clk); g++; end
    g = 0;
    while (out_a && g < 100) begin @(negedge clk); g++; end
    cmp = CW'(7);
    k0 = 0; k1 = 0; run0 = 0; run1 = 0; p0 = 1'b0; p1 = 1'b0;
    r0 = '{0, 0}; r1 = '{0, 0};
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (out_a) run0++;
      else if (p0 && k0 < 2) begin r0[k0] = run0; k0++; run0 = 0; end
      if (out_a1) run1++;
      else if (p1 && k1 < 2) begin r1[k1] = run1; k1++; run1 = 0; end
      p0 = out_a; p1 = out_a1;
    end
    chk(r0[0] == 9, "R7 first pulse trough-only", r0[0], 9);
    chk(r0[1] == 13, "R7 second pulse trough-only", r0[1], 13);
    chk(r1[0] == 13, "R8 first pulse trough+peak", r1[0], 13);
    chk(r1[1] == 13, "R8 second pulse trough+peak", r1[1], 13);
  endtask

  initial begin
    #750000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_strobe();
    t_duty();
    t_dead();
    t_inv();
    t_en();
    t_upd();
    summary();
  end
endmodule